// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer

This block is an 8-bit up-counter. It has two compare registers, an overflow detector, a choice of counter-clear source and three interrupt request outputs, each with its own mask. A small register bus sets it up and reads it back. One control register holds the interrupt masks, the clear mode and the count source. The count source is a stop code, one of three prescaler tick inputs, or an edge of an external clock pin. The external clock pin and the external reset pin each pass through a two-flop synchronizer before their edges are detected.

Each status flag is a three-state machine with the states FLG_IDLE, FLG_PEND and FLG_ARMED:

- LATCH (FLG_IDLE to FLG_PEND): a set event occurs.
- ARM (FLG_PEND to FLG_ARMED): software reads the status register while the flag is set.
- ACK (FLG_ARMED to FLG_IDLE): software writes 0 to that bit.
- RELATCH (FLG_ARMED to FLG_PEND): a new set event arrives before the acknowledge.

In FLG_PEND, a set event keeps the state in FLG_PEND, even in a cycle that also reads the status register. A flag can therefore only be cleared by reading it as 1 and then writing 0 to it. Each interrupt output is its flag ANDed with its mask bit.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, the control register, the counter and the status register read 0. Both compare registers read 0xFF. All three interrupt outputs are low.
- R2: Register addresses: 0 = control, 1 = status, 2 = counter, 3 = compare A, 4 = compare B. Read data is combinational on the address. Control bit layout: bit 7 = compare-B interrupt mask, bit 6 = compare-A interrupt mask, bit 5 = overflow interrupt mask, bits 4:3 = clear mode, bits 2:0 = count source. Status bit layout: bit 0 = overflow flag, bit 1 = compare-A flag, bit 2 = compare-B flag. All other status bits read 0.
- R3: Count source codes 1, 2 and 3 add one to the counter at each clock edge where `presc_tick[code-1]` is high. Codes 0 and 4 hold the counter.
- R4: Count source code 5 counts rising edges of `ext_clk_in`, code 6 counts falling edges and code 7 counts both edges. A change on the pin driven before clock edge k is counted at edge k+2.
- R5: If the counter equals a compare register at a clock edge, the matching flag is set at that edge.
- R6: A counted step from 0xFF to 0x00 sets the overflow flag at the same edge.
- R7: Clear mode 0 never clears the counter. Mode 1 clears it at the edge where it equals compare A. Mode 2 clears it at the edge where it equals compare B.
- R8: In clear mode 3, a rising edge on `ext_rst_in` driven before edge k sets the counter to 0 at edge k+2. A falling edge on that pin has no effect.
- R9: A clear beats a count in the same cycle, and such a step sets no overflow. A bus write to the counter beats both.
- R10: Writing 0 to a status bit clears it only if a status read saw that bit as 1 and no new set event has come since. Writing 1 has no effect.
- R11: Each interrupt output is high exactly when its flag and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms status flags) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| presc_tick | input | 3 | Prescaler tick inputs |
| ext_clk_in | input | 1 | External count pin |
| ext_rst_in | input | 1 | External clear pin |
| irq_cmp_b | output | 1 | Compare-B interrupt request |
| irq_cmp_a | output | 1 | Compare-A interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Timing of each result:

- Register writes, prescaler counts, clears on a match and flag sets all appear one edge after the cycle that causes them.
- A change on an external pin reaches the counter two edges after the edge that first captures it, because of the synchronizer and the edge detector.
- Interrupt outputs and read data follow the state with no added delay.

The bench drives inputs at falling edges and samples one falling edge after each rising edge. For external pins it keeps a three-deep history of the levels it has driven, so each expected count or clear lands on the right edge. It sweeps every compare-A value under clear-on-match and checks the counter after every edge.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int NFLAG = 3;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_STAT = 3'd1;
    localparam logic [AW-1:0] A_CNT  = 3'd2;
    localparam logic [AW-1:0] A_CMPA = 3'd3;
    localparam logic [AW-1:0] A_CMPB = 3'd4;

    typedef enum logic [1:0] {
        FLG_IDLE,
        FLG_PEND,
        FLG_ARMED
    } flag_st_t;

    typedef enum logic [2:0] {
        CK_STOP     = 3'd0,
        CK_PRE0     = 3'd1,
        CK_PRE1     = 3'd2,
        CK_PRE2     = 3'd3,
        CK_RSVD     = 3'd4,
        CK_EXT_RISE = 3'd5,
        CK_EXT_FALL = 3'd6,
        CK_EXT_BOTH = 3'd7
    } clk_code_t;

    typedef enum logic [1:0] {
        CLR_NONE  = 2'd0,
        CLR_CMPA  = 2'd1,
        CLR_CMPB  = 2'd2,
        CLR_EXTPIN = 2'd3
    } clr_mode_t;
endpackage

// File: rtl/dct_sync.sv
`timescale 1ns/1ps
module dct_sync #(
    parameter int W = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_d
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
            lvl_d <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
            lvl_d <= stg[STAGES-1];
        end
    end

    assign lvl = stg[STAGES-1];
endmodule

// File: rtl/dct_tick_sel.sv
`timescale 1ns/1ps
module dct_tick_sel
    import dct_pkg::*;
(
    input  logic [2:0] clk_sel,
    input  logic [2:0] presc_tick,
    input  logic       ext_rise,
    input  logic       ext_fall,
    output logic       tick
);
    always_comb begin
        unique case (clk_code_t'(clk_sel))
            CK_STOP:     tick = 1'b0;
            CK_PRE0:     tick = presc_tick[0];
            CK_PRE1:     tick = presc_tick[1];
            CK_PRE2:     tick = presc_tick[2];
            CK_RSVD:     tick = 1'b0;
            CK_EXT_RISE: tick = ext_rise;
            CK_EXT_FALL: tick = ext_fall;
            CK_EXT_BOTH: tick = ext_rise | ext_fall;
        endcase
    end
endmodule

// File: rtl/dct_flag.sv
`timescale 1ns/1ps
module dct_flag
    import dct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_arm,
    input  logic clr_wr,
    output logic flag
);
    flag_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_IDLE:  if (set_evt) st_d = FLG_PEND;
            FLG_PEND:  if (!set_evt && rd_arm) st_d = FLG_ARMED;
            FLG_ARMED: begin
                if (set_evt)     st_d = FLG_PEND;
                else if (clr_wr) st_d = FLG_IDLE;
            end
            default:   st_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FLG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        flag = (st_q != FLG_IDLE);
    end
endmodule

// File: rtl/dual_cmp_timer.sv
`timescale 1ns/1ps
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [2:0]    presc_tick,
    input  logic          ext_clk_in,
    input  logic          ext_rst_in,
    output logic          irq_cmp_b,
    output logic          irq_cmp_a,
    output logic          irq_ovf
);
    logic [DW-1:0]    ctrl_q, cnt_q, cmp_a_q, cmp_b_q;
    logic [1:0]       pin_lvl, pin_lvl_d;
    logic             ext_rise, ext_fall, rst_rise;
    logic             tick, clr_evt, cnt_wr, ovf_evt, match_a, match_b;
    logic             stat_rd, stat_wr;
    logic [NFLAG-1:0] set_evt, flags;

    dct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ext_rst_in, ext_clk_in}),
        .lvl   (pin_lvl),
        .lvl_d (pin_lvl_d)
    );

    assign ext_rise = pin_lvl[0] & ~pin_lvl_d[0];
    assign ext_fall = ~pin_lvl[0] & pin_lvl_d[0];
    assign rst_rise = pin_lvl[1] & ~pin_lvl_d[1];

    dct_tick_sel u_tick (
        .clk_sel    (ctrl_q[2:0]),
        .presc_tick (presc_tick),
        .ext_rise   (ext_rise),
        .ext_fall   (ext_fall),
        .tick       (tick)
    );

    assign match_a = (cnt_q == cmp_a_q);
    assign match_b = (cnt_q == cmp_b_q);
    assign cnt_wr  = bus_wr && (bus_addr == A_CNT);
    assign stat_wr = bus_wr && (bus_addr == A_STAT);
    assign stat_rd = bus_rd && (bus_addr == A_STAT);

    always_comb begin
        unique case (clr_mode_t'(ctrl_q[4:3]))
            CLR_NONE:   clr_evt = 1'b0;
            CLR_CMPA:   clr_evt = match_a;
            CLR_CMPB:   clr_evt = match_b;
            CLR_EXTPIN: clr_evt = rst_rise;
        endcase
    end

    assign ovf_evt = tick && !clr_evt && !cnt_wr && (cnt_q == {DW{1'b1}});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cnt_q   <= '0;
            cmp_a_q <= '1;
            cmp_b_q <= '1;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) ctrl_q  <= bus_wdata;
            if (bus_wr && bus_addr == A_CMPA) cmp_a_q <= bus_wdata;
            if (bus_wr && bus_addr == A_CMPB) cmp_b_q <= bus_wdata;
            if (cnt_wr)       cnt_q <= bus_wdata;
            else if (clr_evt) cnt_q <= '0;
            else if (tick)    cnt_q <= cnt_q + DW'(1);
        end
    end

    assign set_evt = {match_b, match_a, ovf_evt};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        dct_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_evt[g]),
            .rd_arm  (stat_rd),
            .clr_wr  (stat_wr && !bus_wdata[g]),
            .flag    (flags[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_STAT:  bus_rdata = {{(DW-NFLAG){1'b0}}, flags};
            A_CNT:   bus_rdata = cnt_q;
            A_CMPA:  bus_rdata = cmp_a_q;
            A_CMPB:  bus_rdata = cmp_b_q;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_ovf   = flags[0] & ctrl_q[5];
    assign irq_cmp_a = flags[1] & ctrl_q[6];
    assign irq_cmp_b = flags[2] & ctrl_q[7];
endmodule

// File: rtl/dct_checker.sv
`timescale 1ns/1ps
module dct_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] en,
    input logic [2:0] clk_sel,
    input logic [7:0] cnt,
    input logic [7:0] cmp_a,
    input logic [7:0] cmp_b,
    input logic       tick,
    input logic       clr_evt,
    input logic       cnt_wr,
    input logic [2:0] flags,
    input logic       irq_b,
    input logic       irq_a,
    input logic       irq_o
);
    assert_irq_b_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en[2] |-> !irq_b);
    assert_irq_a_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en[1] |-> !irq_a);
    assert_irq_ovf_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en[0] |-> !irq_o);
    assert_clear_beats_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !cnt_wr) |=> (cnt == 8'd0));
    assert_wrap_sets_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_evt && !cnt_wr && cnt == 8'hFF) |=> (cnt == 8'd0 && flags[0]));
    assert_stop_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_sel == 3'd0 || clk_sel == 3'd4) && !clr_evt && !cnt_wr) |=> $stable(cnt));
    assert_match_a_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == cmp_a) |=> flags[1]);
    assert_match_b_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == cmp_b) |=> flags[2]);
endmodule

bind dual_cmp_timer dct_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_q[7:5]),
    .clk_sel (ctrl_q[2:0]),
    .cnt     (cnt_q),
    .cmp_a   (cmp_a_q),
    .cmp_b   (cmp_b_q),
    .tick    (tick),
    .clr_evt (clr_evt),
    .cnt_wr  (cnt_wr),
    .flags   (flags),
    .irq_b   (irq_cmp_b),
    .irq_a   (irq_cmp_a),
    .irq_o   (irq_ovf)
);

// File: tb/dual_cmp_timer_tb.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd2;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] presc_tick = '0;
    logic       ext_clk_in = 1'b0, ext_rst_in = 1'b0;
    logic       irq_cmp_b, irq_cmp_a, irq_ovf;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    dual_cmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .presc_tick(presc_tick), .ext_clk_in(ext_clk_in), .ext_rst_in(ext_rst_in),
        .irq_cmp_b(irq_cmp_b), .irq_cmp_a(irq_cmp_a), .irq_ovf(irq_ovf)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd2;
    endtask

    task automatic peek(logic [2:0] a, output int v);
        bus_addr = a;
        #1 v = int'(bus_rdata);
        bus_addr = 3'd2;
    endtask

    task automatic rd_stat(output int v);
        bus_addr = 3'd1; bus_rd = 1'b1;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 3'd2;
    endtask

    task automatic sweep_clr(int mode, int n);
        int exp;
        int v;
        presc_tick = 3'd0;
        wr(3'd0, 8'h00);
        wr(mode == 1 ? 3'd3 : 3'd4, 8'(n));
        wr(3'd2, 8'h00);
        presc_tick = 3'b001;
        wr(3'd0, 8'((mode << 3) | 1));
        exp = 0;
        peek(3'd2, v);
        chk("R7 start", v, exp);
        for (int i = 0; i < 2 * (n + 1) + 2; i++) begin
            @(negedge clk);
            exp = (exp == n) ? 0 : ((exp + 1) & 8'hFF);
            peek(3'd2, v);
            chk(mode == 1 ? "R7 R9 clear on A" : "R7 R9 clear on B", v, exp);
        end
        presc_tick = 3'd0;
        wr(3'd0, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v, exp;
        bit q1, q2, q3, nv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        peek(3'd0, v); chk("R1 ctrl", v, 0);
        peek(3'd1, v); chk("R1 status", v, 0);
        peek(3'd2, v); chk("R1 counter", v, 0);
        peek(3'd3, v); chk("R1 cmpA", v, 8'hFF);
        peek(3'd4, v); chk("R1 cmpB", v, 8'hFF);
        chk("R1 irqs", {irq_cmp_b, irq_cmp_a, irq_ovf}, 0);

        // R2 register access
        wr(3'd3, 8'h5A); peek(3'd3, v); chk("R2 cmpA rw", v, 8'h5A);
        wr(3'd4, 8'hA5); peek(3'd4, v); chk("R2 cmpB rw", v, 8'hA5);
        wr(3'd0, 8'hE4); peek(3'd0, v); chk("R2 ctrl rw", v, 8'hE4);
        peek(3'd5, v); chk("R2 unmapped", v, 0);
        wr(3'd0, 8'h00);

        // R7 R9 sweep every compare-A value, a few compare-B values
        for (int n = 0; n < 256; n++) sweep_clr(1, n);
        sweep_clr(2, 0); sweep_clr(2, 1); sweep_clr(2, 7);
        sweep_clr(2, 128); sweep_clr(2, 255);
        wr(3'd3, 8'hF0); wr(3'd4, 8'hF0);

        // R3 prescaler codes and stop codes
        for (int code = 0; code < 5; code++) begin
            wr(3'd0, 8'h00);
            wr(3'd2, 8'h00);
            wr(3'd0, 8'(code));
            exp = 0;
            for (int i = 0; i < 40; i++) begin
                for (int j = 0; j < 3; j++) presc_tick[j] = ((i % (j + 2)) == 0);
                @(negedge clk);
                if (code >= 1 && code <= 3 && presc_tick[code-1]) exp++;
                peek(3'd2, v);
                chk("R3 prescaler count", v, exp);
            end
            presc_tick = 3'd0;
        end
        wr(3'd0, 8'h00);

        // R4 external clock edges
        for (int code = 5; code < 8; code++) begin
            ext_clk_in = 1'b0;
            wr(3'd0, 8'h00);
            repeat (4) @(negedge clk);
            wr(3'd2, 8'h00);
            wr(3'd0, 8'(code));
            q1 = 0; q2 = 0; q3 = 0; exp = 0;
            for (int i = 0; i < 48; i++) begin
                nv = (((i / 3) + (i / 5)) % 2) == 1;
                ext_clk_in = nv;
                @(negedge clk);
                if ((code != 6) && q2 && !q3) exp++;
                if ((code != 5) && !q2 && q3) exp++;
                peek(3'd2, v);
                chk("R4 external count", v, exp);
                q3 = q2; q2 = q1; q1 = nv;
            end
        end
        ext_clk_in = 1'b0;
        wr(3'd0, 8'h00);
        repeat (4) @(negedge clk);

        // R8 clear on external pin rising edge only
        wr(3'd2, 8'h00);
        presc_tick = 3'b001;
        wr(3'd0, 8'b000_11_001);
        q1 = 0; q2 = 0; q3 = 0; exp = 0;
        for (int i = 0; i < 60; i++) begin
            nv = (i % 13) >= 4 && (i % 13) < 8;
            ext_rst_in = nv;
            @(negedge clk);
            exp = (q2 && !q3) ? 0 : ((exp + 1) & 8'hFF);
            peek(3'd2, v);
            chk("R8 external clear", v, exp);
            q3 = q2; q2 = q1; q1 = nv;
        end
        ext_rst_in = 1'b0;

        // R9 bus write beats count
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h40);
        peek(3'd2, v); chk("R9 write beats tick", v, 8'h40);
        @(negedge clk);
        peek(3'd2, v); chk("R9 counts after write", v, 8'h41);
        presc_tick = 3'd0;
        wr(3'd0, 8'h00);

        // R10 clear all flags away from matches
        wr(3'd2, 8'h80); wr(3'd3, 8'h10); wr(3'd4, 8'h20);
        rd_stat(v);
        wr(3'd1, 8'h00);
        peek(3'd1, v); chk("R10 read then write 0 clears", v, 0);

        // R6 overflow, R11 masked
        wr(3'd2, 8'hFE);
        presc_tick = 3'b001;
        wr(3'd0, 8'h01);
        @(negedge clk);
        peek(3'd2, v); chk("R6 reach FF", v, 8'hFF);
        @(negedge clk);
        peek(3'd2, v); chk("R6 wrap to 0", v, 0);
        peek(3'd1, v); chk("R6 overflow flag", v, 1);
        chk("R11 ovf masked", irq_ovf, 0);
        presc_tick = 3'd0;
        wr(3'd0, 8'h20);
        chk("R11 ovf enabled", irq_ovf, 1);

        // R10 protocol
        wr(3'd1, 8'h00);
        peek(3'd1, v); chk("R10 write 0 without read", v, 1);
        rd_stat(v); chk("R10 read sees flag", v, 1);
        wr(3'd1, 8'hFF);
        peek(3'd1, v); chk("R10 write 1 no effect", v, 1);
        wr(3'd1, 8'h00);
        peek(3'd1, v); chk("R10 acknowledged", v, 0);
        chk("R11 ovf drops", irq_ovf, 0);

        // R5 compare flags, R11 per-source gating
        wr(3'd2, 8'h80);
        wr(3'd3, 8'h80);
        @(negedge clk);
        peek(3'd1, v); chk("R5 match A flag", v, 2);
        chk("R11 A masked", irq_cmp_a, 0);
        wr(3'd0, 8'h40);
        chk("R11 A enabled", irq_cmp_a, 1);
        wr(3'd4, 8'h80);
        @(negedge clk);
        peek(3'd1, v); chk("R5 match B flag", v, 6);
        wr(3'd0, 8'h80);
        chk("R11 B enabled", irq_cmp_b, 1);
        chk("R11 A now masked", irq_cmp_a, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule